// File: doc/BRIEF.md
# Interrupt Status and Mask Unit

This block holds a 32-bit interrupt status word and a matching 32-bit mask word for a storage-card host controller. Single-cycle event pulses from the command engine, the data path, the FIFO and the card-detect logic set sticky flags at fixed bit positions. Software acknowledges a flag by writing a 0 to its bit; a 1 leaves the bit as it was. Two bits of the same word show live pin state (card present, write protect). They cannot be acknowledged and raise no interrupt.

A registered interrupt line is high whenever any sticky flag is set and its mask bit is 0; a mask bit of 1 disables that source. Writing a new command clears the error group in bits 16 to 22. A held soft reset keeps every flag cleared and leaves the mask alone.

Top module: `irq_status_unit`

## Requirements
- R1: After reset, `status_o` sticky bits are 0, `mask_o` is 32'h8B7F031D (every source disabled) and `irq_o` is 0.
- R2: A pulse on `event_i[b]` sets sticky flag b on the next clock edge, and the flag then stays set. The sticky positions are 0 response end, 2 data end, 3 card removed, 4 card inserted, 16 command index error, 17 CRC fail, 18 end-bit error, 19 data timeout, 20 RX overflow, 21 TX underrun, 22 command timeout, 24 RX ready, 25 TX request and 31 illegal access. The sticky set is 32'h837F001D.
- R3: A write on `status_we_i` clears each sticky flag whose `status_wdata_i` bit is 0. Flags whose bit is 1 keep their value.
- R4: If an event and a write-0 acknowledge reach the same bit in the same cycle, the flag is set after that edge.
- R5: `irq_o` is the registered OR over the sticky bits of (flag AND NOT mask). It changes one clock after the flag or mask it follows.
- R6: Bit 5 of `status_o` follows `card_present_i` and bit 7 follows `wr_protect_i` combinationally. Writes do not clear them, and they never drive `irq_o`.
- R7: Status bits 1, 6, 8 to 15, 23, 26 to 30 always read 0, and events on those positions are ignored.
- R8: A pulse on `cmd_write_i` clears flags 16 to 22 on the next edge and leaves all other flags as they were. An event on the same bit in that cycle still wins.
- R9: While `soft_rst_i` is high, all sticky flags are held at 0 and events are ignored. The mask is not changed.
- R10: `mask_we_i` stores `mask_wdata_i` in bits 0, 2, 3, 4, 8, 9, 16 to 22, 24, 25, 27 and 31. All other mask bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| event_i | input | 32 | Event pulses, one per status bit position |
| card_present_i | input | 1 | Live card-present level |
| wr_protect_i | input | 1 | Live write-protect level |
| status_we_i | input | 1 | Status acknowledge write strobe |
| status_wdata_i | input | 32 | Acknowledge data (0 clears, 1 keeps) |
| mask_we_i | input | 1 | Mask write strobe |
| mask_wdata_i | input | 32 | Mask data (1 disables) |
| cmd_write_i | input | 1 | New command written; clears error flags |
| soft_rst_i | input | 1 | Soft reset, active high, level held |
| status_o | output | 32 | Status word: sticky flags and live bits |
| mask_o | output | 32 | Mask word |
| irq_o | output | 1 | Registered interrupt request |

## Verification
Assertions check on every cycle the properties that hold locally. An event sets its flag on the next edge even when an acknowledge or a command write hits the same bit. A held soft reset empties the flag bank. Reserved and non-writable positions stay zero. An unmasked flag raises the interrupt one edge later. Only the bench scenarios show that the live pin bits survive acknowledges, that command writes spare the non-error flags, and that the mask keeps its contents through a soft reset. They also show that masking a pending flag holds the interrupt low and that unmasking it raises the line after the expected two edges.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned W = 32;

  localparam int unsigned B_RESP_END  = 0;
  localparam int unsigned B_DATA_END  = 2;
  localparam int unsigned B_CARD_OUT  = 3;
  localparam int unsigned B_CARD_IN   = 4;
  localparam int unsigned B_PRESENT   = 5;
  localparam int unsigned B_WPROT     = 7;
  localparam int unsigned B_ERR_LO    = 16;
  localparam int unsigned B_ERR_HI    = 22;
  localparam int unsigned B_RX_RDY    = 24;
  localparam int unsigned B_TX_REQ    = 25;
  localparam int unsigned B_ILLEGAL   = 31;

  localparam logic [W-1:0] ERR_MSK  = 32'h007F_0000;
  localparam logic [W-1:0] FLAG_MSK = (W'(1) << B_RESP_END) | (W'(1) << B_DATA_END)
                                    | (W'(1) << B_CARD_OUT) | (W'(1) << B_CARD_IN)
                                    | ERR_MSK | (W'(1) << B_RX_RDY)
                                    | (W'(1) << B_TX_REQ) | (W'(1) << B_ILLEGAL);
  localparam logic [W-1:0] LIVE_MSK = (W'(1) << B_PRESENT) | (W'(1) << B_WPROT);
  // extra mask-only storage positions
  localparam logic [W-1:0] MASK_RW  = FLAG_MSK | 32'h0800_0300;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
  import irq_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] event_i,
  input  logic         ack_we_i,
  input  logic [W-1:0] ack_data_i,
  input  logic         cmd_write_i,
  input  logic         soft_rst_i,
  output logic [W-1:0] flags_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    if (FLAG_MSK[b]) begin : g_flag
      logic flag_q;
      logic clr;
      assign clr = (ack_we_i && !ack_data_i[b]) || (cmd_write_i && ERR_MSK[b]);
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)          flag_q <= 1'b0;
        else if (soft_rst_i)  flag_q <= 1'b0;
        else if (event_i[b])  flag_q <= 1'b1;  // event beats any clear
        else if (clr)         flag_q <= 1'b0;
      end
      assign flags_o[b] = flag_q;
    end else begin : g_zero
      assign flags_o[b] = 1'b0;
    end
  end

  assert_evt_sets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((event_i & FLAG_MSK) != '0) && !soft_rst_i)
      |=> ((flags_o & $past(event_i & FLAG_MSK)) == $past(event_i & FLAG_MSK)));

  assert_evt_wins_ack_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_we_i && ((event_i & ~ack_data_i & FLAG_MSK) != '0) && !soft_rst_i)
      |=> ((flags_o & $past(event_i & ~ack_data_i & FLAG_MSK))
           == $past(event_i & ~ack_data_i & FLAG_MSK)));

  assert_ack_clears_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_we_i && !soft_rst_i)
      |=> ((flags_o & $past(~ack_data_i & ~event_i & FLAG_MSK)) == '0));

  assert_cmd_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_write_i && !soft_rst_i)
      |=> ((flags_o & $past(ERR_MSK & ~event_i)) == '0));

  assert_soft_rst_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (flags_o == '0));

  assert_reserved_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_o & ~FLAG_MSK) == '0);
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
  import irq_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] mask_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    if (MASK_RW[b]) begin : g_rw
      logic m_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   m_q <= 1'b1;  // disabled out of reset
        else if (we_i) m_q <= wdata_i[b];
      end
      assign mask_o[b] = m_q;
    end else begin : g_ro
      assign mask_o[b] = 1'b0;
    end
  end

  assert_mask_ro_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_o & ~MASK_RW) == '0);

  assert_mask_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(mask_o));
endmodule

// File: rtl/irq_out_reg.sv
module irq_out_reg
  import irq_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] flags_i,
  input  logic [W-1:0] mask_i,
  output logic         irq_o
);
  logic pend;
  logic irq_q;
  assign pend = |(flags_i & ~mask_i & FLAG_MSK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= pend;
  end
  assign irq_o = irq_q;

  assert_irq_rise_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((flags_i & ~mask_i) != '0) |=> irq_o);

  assert_irq_fall_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((flags_i & ~mask_i) == '0) |=> !irq_o);
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import irq_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [31:0]  event_i,
  input  logic         card_present_i,
  input  logic         wr_protect_i,
  input  logic         status_we_i,
  input  logic [31:0]  status_wdata_i,
  input  logic         mask_we_i,
  input  logic [31:0]  mask_wdata_i,
  input  logic         cmd_write_i,
  input  logic         soft_rst_i,
  output logic [31:0]  status_o,
  output logic [31:0]  mask_o,
  output logic         irq_o
);
  logic [W-1:0] flags;
  logic [W-1:0] live;

  irq_flag_bank u_flags (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .event_i     (event_i),
    .ack_we_i    (status_we_i),
    .ack_data_i  (status_wdata_i),
    .cmd_write_i (cmd_write_i),
    .soft_rst_i  (soft_rst_i),
    .flags_o     (flags)
  );

  irq_mask_reg u_mask (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (mask_we_i),
    .wdata_i (mask_wdata_i),
    .mask_o  (mask_o)
  );

  irq_out_reg u_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flags_i (flags),
    .mask_i  (mask_o),
    .irq_o   (irq_o)
  );

  always_comb begin
    live = '0;
    live[B_PRESENT] = card_present_i;
    live[B_WPROT]   = wr_protect_i;
  end
  assign status_o = flags | live;

  assert_live_bits_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[B_PRESENT] == card_present_i) && (status_o[B_WPROT] == wr_protect_i));
endmodule

// File: tb/sim_irq_status_unit.sv
module sim_irq_status_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] event_i = '0;
  logic        card_present = 1'b0;
  logic        wr_protect = 1'b0;
  logic        status_we = 1'b0;
  logic [31:0] status_wdata = '0;
  logic        mask_we = 1'b0;
  logic [31:0] mask_wdata = '0;
  logic        cmd_write = 1'b0;
  logic        soft_rst = 1'b0;
  logic [31:0] status_o, mask_o;
  logic        irq_o;

  int n_run = 0, n_fail = 0;
  localparam logic [31:0] ALL_FLAGS = 32'h837F001D;
  localparam logic [31:0] MASK_ALL  = 32'h8B7F031D;

  always #2.5 clk = ~clk;

  irq_status_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .event_i(event_i),
    .card_present_i(card_present), .wr_protect_i(wr_protect),
    .status_we_i(status_we), .status_wdata_i(status_wdata),
    .mask_we_i(mask_we), .mask_wdata_i(mask_wdata),
    .cmd_write_i(cmd_write), .soft_rst_i(soft_rst),
    .status_o(status_o), .mask_o(mask_o), .irq_o(irq_o)
  );

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  // one clock: inputs set before call are sampled at the posedge
  task automatic step();
    @(negedge clk);
    event_i = '0; status_we = 1'b0; mask_we = 1'b0; cmd_write = 1'b0;
  endtask

  task automatic set_mask(logic [31:0] v);
    mask_we = 1'b1; mask_wdata = v; step();
  endtask

  task automatic ack(logic [31:0] v);
    status_we = 1'b1; status_wdata = v; step();
  endtask

  task automatic fire(logic [31:0] v);
    event_i = v; step();
  endtask

  task automatic t_reset();
    chk("R1 status", status_o, 32'h0);
    chk("R1 mask", mask_o, MASK_ALL);
    chk("R1 irq", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_sticky();
    set_mask(32'h0);
    chk("R10 mask cleared", mask_o, 32'h0);
    fire(32'h4);
    chk("R2 data end set", status_o, 32'h4);
    chk("R5 irq lags flag", {31'b0, irq_o}, 32'h0);
    step();
    chk("R5 irq after one edge", {31'b0, irq_o}, 32'h1);
    step(); step();
    chk("R2 flag sticky", status_o, 32'h4);
    fire(32'hFFFFFFFF);
    chk("R7 reserved ignored", status_o, ALL_FLAGS);
  endtask

  task automatic t_ack();
    ack(~32'h1);
    chk("R3 write0 clears bit0", status_o, ALL_FLAGS & ~32'h1);
    ack(32'hFFFFFFFF);
    chk("R3 write1 keeps", status_o, ALL_FLAGS & ~32'h1);
    ack(32'h0);
    chk("R3 clear all", status_o, 32'h0);
    step();
    chk("R5 irq drops", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_race();
    event_i = 32'h8; status_we = 1'b1; status_wdata = ~32'h8; step();
    chk("R4 event beats ack", status_o, 32'h8);
    ack(32'h0);
    chk("R4 later ack clears", status_o, 32'h0);
  endtask

  task automatic t_mask();
    set_mask(32'hFFFFFFFF);
    chk("R10 writable bits", mask_o, MASK_ALL);
    fire(32'h0100_0000);
    step(); step();
    chk("R5 masked no irq", {31'b0, irq_o}, 32'h0);
    set_mask(MASK_ALL & ~32'h0100_0000);
    chk("R10 mask value", mask_o, 32'h8A7F031D);
    chk("R5 irq not yet", {31'b0, irq_o}, 32'h0);
    step();
    chk("R5 unmask raises irq", {31'b0, irq_o}, 32'h1);
    ack(32'h0);
    set_mask(32'h0);
  endtask

  task automatic t_live();
    step();
    card_present = 1'b1; wr_protect = 1'b1;
    #1;
    chk("R6 live bits follow", status_o, 32'hA0);
    ack(32'h0);
    chk("R6 live not cleared", status_o, 32'hA0);
    step();
    chk("R6 no irq from live", {31'b0, irq_o}, 32'h0);
    card_present = 1'b0;
    #1;
    chk("R6 present drops", status_o, 32'h80);
    wr_protect = 1'b0;
  endtask

  task automatic t_cmd();
    fire(32'hFFFFFFFF);
    cmd_write = 1'b1; step();
    chk("R8 cmd clears errors", status_o, ALL_FLAGS & ~32'h007F0000);
    event_i = 32'h0002_0000; cmd_write = 1'b1; step();
    chk("R8 event beats cmd clear", status_o, (ALL_FLAGS & ~32'h007F0000) | 32'h0002_0000);
    ack(32'h0);
  endtask

  task automatic t_soft();
    set_mask(32'h0000_0300);
    fire(32'h8000_0001);
    soft_rst = 1'b1; step();
    chk("R9 flags cleared", status_o, 32'h0);
    fire(32'h0000_0004);
    chk("R9 events ignored while held", status_o, 32'h0);
    chk("R9 mask kept", mask_o, 32'h0000_0300);
    soft_rst = 1'b0; step();
    chk("R9 still clear after release", status_o, 32'h0);
    chk("R9 irq low", {31'b0, irq_o}, 32'h0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    t_reset();
    t_sticky();
    t_ack();
    t_race();
    t_mask();
    t_live();
    t_cmd();
    t_soft();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule